// File: doc/BRIEF.md
# Synthesizer Serial Programming Port

This block is the digital front end through which a host programs a fractional-N frequency synthesizer. A three-wire serial link (serial clock, serial data, latch strobe) carries 24-bit words. The block assembles each word in a shift register and decodes the word's type from its top bits. It then moves the fields into working registers that drive the main divider, the reference divider, the auxiliary divider and the transmit control functions.

Writes to the main divider are handled with care, because an abrupt change of ratio would disturb the loop phase. A main-divider word does not load when the strobe rises. It is held until the divider reports a terminal-count sync pulse while the strobe is still high. The compensation DAC value is written earlier by the reference word and parked in a staging register. It only reaches its working register in the same cycle as a main-divider commit. After such a commit, a speed-up flag tells the charge-pump logic to use its fast mode until the strobe falls.

Each register group raises a one-cycle update pulse when it is written. The serial inputs are assumed to be already synchronous to the system clock `clk_i`; edges are detected against the previous sample.

Top module: `synth_serial_prog`

## Requirements
- R1: While `ser_strobe_i` is low, every rising edge of `ser_clk_i` shifts `ser_data_i` into a 24-bit shift register. While `ser_strobe_i` is high, serial clock edges are ignored and the register holds its contents. A strobe rise that follows a stretch of clocks sent with the strobe high therefore reloads the previous word unchanged.
- R2: Bits arrive least significant first. The 24th bit shifted in becomes bit 23 of the word.
- R3: Word type is decoded from the top bits. Bits [23:22]=00 selects the main word, 01 the reference word and 10 the auxiliary word. Bits [23:21]=110 selects the control word. A word with bits [23:21]=111 is ignored: no update pulse occurs and no output changes.
- R4: Reference, auxiliary and control words load in the cycle that the strobe rise is sampled, and the matching update pulse (`upd_ref_o`, `upd_aux_o`, `upd_ctl_o`) is high for exactly that one cycle. The fields are placed as follows.
  - Reference word: ratio in [21:12], main tap in [11:10], aux tap in [9:8], DAC value in [7:0].
  - Auxiliary word: ratio in [21:8], pump ratio in [7:6], lock select in [5:4], main power in [3], aux power in [2].
  - Control word: power control in [20:13], M select in [12:11], offset enable in [10], tx mode in [9], digital mode in [8], TX LO buffer enable in [7], reference clock buffer enable in [6].
- R5: The DAC field of a reference word goes only to a staging register. `comp_dac_o` changes only in the cycle of a main commit, and it then takes the most recently staged value.
- R6: A main word has its modulus flag in [21], its increment in [20:18] and its ratio in [17:2]. It commits, with a one-cycle `upd_main_o` pulse, at the first sampled `div_sync_i` pulse after its strobe rise while the strobe stays high. Only one commit is made per strobe rise. If the strobe falls before a sync pulse arrives, the word is dropped. A sync pulse with no main word pending has no effect.
- R7: `speedup_o` rises in the cycle after a main commit and stays high until the first cycle in which the strobe is sampled low, after which it is low.
- R8: After reset, the outputs hold these defaults:
  - main: modulus 0, increment 0, ratio 1024;
  - reference: ratio 100, both taps 0, DAC 80;
  - auxiliary: ratio 512, pump 0, lock select 0, both power bits 0;
  - control: all fields 0;
  - `speedup_o` and all update pulses: 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ser_clk_i | input | 1 | Serial shift clock, sampled |
| ser_data_i | input | 1 | Serial data, LSB first |
| ser_strobe_i | input | 1 | Latch strobe; high freezes the shifter and latches |
| div_sync_i | input | 1 | Main divider terminal-count sync pulse |
| frac_mod_o | output | 1 | Fractional modulus select |
| frac_inc_o | output | 3 | Fractional increment |
| main_ratio_o | output | 16 | Main divider ratio |
| ref_ratio_o | output | 10 | Reference divider ratio |
| main_tap_o | output | 2 | Reference tap for main detector |
| aux_tap_o | output | 2 | Reference tap for aux detector |
| comp_dac_o | output | 8 | Compensation DAC working value |
| aux_ratio_o | output | 14 | Auxiliary divider ratio |
| pump_ratio_o | output | 2 | Charge pump current ratio |
| lock_sel_o | output | 2 | Lock indicator source select |
| main_pwr_o | output | 1 | Main loop power enable |
| aux_pwr_o | output | 1 | Aux loop power enable |
| pwr_ctl_o | output | 8 | Output power attenuation code |
| mdiv_sel_o | output | 2 | Offset loop divider select |
| offset_en_o | output | 1 | Offset synthesizer enable |
| tx_mode_o | output | 1 | Transmit mode bit |
| dig_mode_o | output | 1 | Digital/analog mode bit |
| txlo_buf_en_o | output | 1 | TX LO buffer enable |
| rclk_buf_en_o | output | 1 | Reference clock buffer enable |
| speedup_o | output | 1 | Charge pump speed-up request |
| upd_main_o | output | 1 | Main group commit pulse |
| upd_ref_o | output | 1 | Reference group update pulse |
| upd_aux_o | output | 1 | Auxiliary group update pulse |
| upd_ctl_o | output | 1 | Control group update pulse |

## Verification
The bench targets these corner cases.

- **Dropped main word.** A main word is strobed with no sync pulse. A design that loaded on the strobe rise would change the main ratio here.
- **DAC staging.** Two reference words are sent before a main word. A design that did not stage the DAC would move `comp_dac_o` early, and one that staged wrongly would copy the older DAC value.
- **Repeated sync.** A second sync pulse arrives during the same strobe. A design that does not clear its pending flag would commit twice.
- **Serial clocks with the strobe high.** These must be ignored. A design that kept shifting would reload a corrupted word.
- **Reserved 111 word.** A decoder that only looked at two address bits would write the control group.
- **Speed-up timing.** The speed-up flag is checked on the cycle the strobe is released and on the cycle after. A late or sticky flag shows up there.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;
  localparam int WORD_W = 24;
  localparam int DAC_W  = 8;

  typedef enum logic [2:0] {WK_MAIN, WK_REF, WK_AUX, WK_CTL, WK_NONE} word_kind_e;

  typedef struct packed {
    logic        frac_mod;
    logic [2:0]  frac_inc;
    logic [15:0] main_ratio;
  } main_cfg_t;

  typedef struct packed {
    logic [9:0] ref_ratio;
    logic [1:0] main_tap;
    logic [1:0] aux_tap;
  } ref_cfg_t;

  typedef struct packed {
    logic [13:0] aux_ratio;
    logic [1:0]  pump_ratio;
    logic [1:0]  lock_sel;
    logic        main_pwr;
    logic        aux_pwr;
  } aux_cfg_t;

  typedef struct packed {
    logic [7:0] pwr_ctl;
    logic [1:0] mdiv_sel;
    logic       offset_en;
    logic       tx_mode;
    logic       dig_mode;
    logic       txlo_buf_en;
    logic       rclk_buf_en;
  } ctl_cfg_t;

  localparam main_cfg_t MAIN_RST = '{frac_mod: 1'b0, frac_inc: 3'd0, main_ratio: 16'd1024};
  localparam ref_cfg_t  REF_RST  = '{ref_ratio: 10'd100, main_tap: 2'd0, aux_tap: 2'd0};
  localparam aux_cfg_t  AUX_RST  = '{aux_ratio: 14'd512, pump_ratio: 2'd0, lock_sel: 2'd0,
                                     main_pwr: 1'b0, aux_pwr: 1'b0};
  localparam ctl_cfg_t  CTL_RST  = '0;
  localparam logic [DAC_W-1:0] DAC_RST = 8'd80;

  function automatic word_kind_e decode_kind(logic [WORD_W-1:0] w);
    unique case (w[WORD_W-1 -: 2])
      2'b00:   return WK_MAIN;
      2'b01:   return WK_REF;
      2'b10:   return WK_AUX;
      default: return w[WORD_W-3] ? WK_NONE : WK_CTL;
    endcase
  endfunction

  function automatic main_cfg_t get_main(logic [WORD_W-1:0] w);
    return main_cfg_t'(w[21:2]);
  endfunction

  function automatic ref_cfg_t get_ref(logic [WORD_W-1:0] w);
    return ref_cfg_t'(w[21:8]);
  endfunction

  function automatic aux_cfg_t get_aux(logic [WORD_W-1:0] w);
    return aux_cfg_t'(w[21:2]);
  endfunction

  function automatic ctl_cfg_t get_ctl(logic [WORD_W-1:0] w);
    return ctl_cfg_t'(w[20:6]);
  endfunction
endpackage

// File: rtl/prog_shift.sv
module prog_shift #(
  parameter int W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ser_clk_i,
  input  logic         ser_data_i,
  input  logic         ser_strobe_i,
  output logic [W-1:0] word_o,
  output logic         load_o
);
  logic         sclk_q, strobe_q;
  logic [W-1:0] sr_q;
  logic         shift_en;

  assign shift_en = ser_clk_i & ~sclk_q & ~ser_strobe_i;
  assign load_o   = ser_strobe_i & ~strobe_q;
  assign word_o   = sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q   <= 1'b0;
      strobe_q <= 1'b1;  // no spurious load if strobe is high at release
      sr_q     <= '0;
    end else begin
      sclk_q   <= ser_clk_i;
      strobe_q <= ser_strobe_i;
      if (shift_en) sr_q <= {ser_data_i, sr_q[W-1:1]};
    end
  end

  AST_HOLD_WHILE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ser_strobe_i |=> $stable(sr_q)); // R1

  AST_LSB_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ser_clk_i && !sclk_q && !ser_strobe_i) |=> (sr_q[W-1] == $past(ser_data_i))); // R2
endmodule

// File: rtl/prog_decode.sv
module prog_decode
  import synth_prog_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  input  logic              load_i,
  output logic              ld_main_o,
  output logic              ld_ref_o,
  output logic              ld_aux_o,
  output logic              ld_ctl_o
);
  word_kind_e kind;

  always_comb begin
    kind      = decode_kind(word_i);
    ld_main_o = load_i && (kind == WK_MAIN);
    ld_ref_o  = load_i && (kind == WK_REF);
    ld_aux_o  = load_i && (kind == WK_AUX);
    ld_ctl_o  = load_i && (kind == WK_CTL);
  end
endmodule

// File: rtl/prog_main_sync.sv
module prog_main_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  input  logic arm_i,
  input  logic sync_i,
  output logic commit_o,
  output logic speedup_o
);
  logic pend_q, fast_q;

  assign commit_o  = pend_q & strobe_i & sync_i;
  assign speedup_o = fast_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      fast_q <= 1'b0;
    end else if (!strobe_i) begin
      pend_q <= 1'b0;  // strobe released early: word dropped
      fast_q <= 1'b0;
    end else begin
      if (arm_i)         pend_q <= 1'b1;
      else if (commit_o) pend_q <= 1'b0;
      if (commit_o)      fast_q <= 1'b1;
    end
  end

  AST_SPEEDUP_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |=> !speedup_o); // R7

  AST_SPEEDUP_FROM_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(speedup_o) |-> ($past(sync_i) && $past(strobe_i))); // R7

  AST_SINGLE_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> !commit_o); // R6
endmodule

// File: rtl/synth_serial_prog.sv
module synth_serial_prog
  import synth_prog_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ser_clk_i,
  input  logic        ser_data_i,
  input  logic        ser_strobe_i,
  input  logic        div_sync_i,
  output logic        frac_mod_o,
  output logic [2:0]  frac_inc_o,
  output logic [15:0] main_ratio_o,
  output logic [9:0]  ref_ratio_o,
  output logic [1:0]  main_tap_o,
  output logic [1:0]  aux_tap_o,
  output logic [7:0]  comp_dac_o,
  output logic [13:0] aux_ratio_o,
  output logic [1:0]  pump_ratio_o,
  output logic [1:0]  lock_sel_o,
  output logic        main_pwr_o,
  output logic        aux_pwr_o,
  output logic [7:0]  pwr_ctl_o,
  output logic [1:0]  mdiv_sel_o,
  output logic        offset_en_o,
  output logic        tx_mode_o,
  output logic        dig_mode_o,
  output logic        txlo_buf_en_o,
  output logic        rclk_buf_en_o,
  output logic        speedup_o,
  output logic        upd_main_o,
  output logic        upd_ref_o,
  output logic        upd_aux_o,
  output logic        upd_ctl_o
);
  logic [WORD_W-1:0] word;
  logic              load;
  logic              ld_main, ld_ref, ld_aux, ld_ctl, commit;

  prog_shift #(.W(WORD_W)) u_shift (
    .clk_i, .rst_ni, .ser_clk_i, .ser_data_i, .ser_strobe_i,
    .word_o(word), .load_o(load)
  );

  prog_decode u_decode (
    .word_i(word), .load_i(load),
    .ld_main_o(ld_main), .ld_ref_o(ld_ref), .ld_aux_o(ld_aux), .ld_ctl_o(ld_ctl)
  );

  prog_main_sync u_main_sync (
    .clk_i, .rst_ni, .strobe_i(ser_strobe_i), .arm_i(ld_main), .sync_i(div_sync_i),
    .commit_o(commit), .speedup_o
  );

  main_cfg_t        main_q;
  ref_cfg_t         ref_q;
  aux_cfg_t         aux_q;
  ctl_cfg_t         ctl_q;
  logic [DAC_W-1:0] dac_stage_q, dac_q;
  logic [3:0]       upd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      main_q      <= MAIN_RST;
      ref_q       <= REF_RST;
      aux_q       <= AUX_RST;
      ctl_q       <= CTL_RST;
      dac_stage_q <= DAC_RST;
      dac_q       <= DAC_RST;
      upd_q       <= '0;
    end else begin
      upd_q <= {ld_ctl, ld_aux, ld_ref, commit};
      // word held in shifter while strobe is high, read it at commit
      if (commit) begin
        main_q <= get_main(word);
        dac_q  <= dac_stage_q;
      end
      if (ld_ref) begin
        ref_q       <= get_ref(word);
        dac_stage_q <= word[DAC_W-1:0];
      end
      if (ld_aux) aux_q <= get_aux(word);
      if (ld_ctl) ctl_q <= get_ctl(word);
    end
  end

  assign {upd_ctl_o, upd_aux_o, upd_ref_o, upd_main_o} = upd_q;
  assign frac_mod_o    = main_q.frac_mod;
  assign frac_inc_o    = main_q.frac_inc;
  assign main_ratio_o  = main_q.main_ratio;
  assign ref_ratio_o   = ref_q.ref_ratio;
  assign main_tap_o    = ref_q.main_tap;
  assign aux_tap_o     = ref_q.aux_tap;
  assign comp_dac_o    = dac_q;
  assign aux_ratio_o   = aux_q.aux_ratio;
  assign pump_ratio_o  = aux_q.pump_ratio;
  assign lock_sel_o    = aux_q.lock_sel;
  assign main_pwr_o    = aux_q.main_pwr;
  assign aux_pwr_o     = aux_q.aux_pwr;
  assign pwr_ctl_o     = ctl_q.pwr_ctl;
  assign mdiv_sel_o    = ctl_q.mdiv_sel;
  assign offset_en_o   = ctl_q.offset_en;
  assign tx_mode_o     = ctl_q.tx_mode;
  assign dig_mode_o    = ctl_q.dig_mode;
  assign txlo_buf_en_o = ctl_q.txlo_buf_en;
  assign rclk_buf_en_o = ctl_q.rclk_buf_en;

  AST_MAIN_ON_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_main_o |-> ($past(div_sync_i) && $past(ser_strobe_i))); // R6

  AST_DAC_WITH_MAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(comp_dac_o) |-> upd_main_o); // R5

  AST_MAIN_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(main_ratio_o) |-> upd_main_o); // R6

  AST_UPD_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({upd_main_o, upd_ref_o, upd_aux_o, upd_ctl_o})); // R4

  AST_REF_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_ref_o |-> ($past(ser_strobe_i) && $past(load))); // R4
endmodule

// File: tb/test_synth_serial_prog.sv
module test_synth_serial_prog;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_strobe = 1'b0, div_sync = 1'b0;
  logic frac_mod, main_pwr, aux_pwr, offset_en, tx_mode, dig_mode, txlo_en, rclk_en;
  logic [2:0] frac_inc;
  logic [15:0] main_ratio;
  logic [9:0] ref_ratio;
  logic [1:0] main_tap, aux_tap, pump_ratio, lock_sel, mdiv_sel;
  logic [7:0] comp_dac, pwr_ctl;
  logic [13:0] aux_ratio;
  logic speedup, upd_main, upd_ref, upd_aux, upd_ctl;

  always #5 clk = ~clk;

  synth_serial_prog i_synth_serial_prog (
    .clk_i(clk), .rst_ni, .ser_clk_i(ser_clk), .ser_data_i(ser_data),
    .ser_strobe_i(ser_strobe), .div_sync_i(div_sync),
    .frac_mod_o(frac_mod), .frac_inc_o(frac_inc), .main_ratio_o(main_ratio),
    .ref_ratio_o(ref_ratio), .main_tap_o(main_tap), .aux_tap_o(aux_tap),
    .comp_dac_o(comp_dac), .aux_ratio_o(aux_ratio), .pump_ratio_o(pump_ratio),
    .lock_sel_o(lock_sel), .main_pwr_o(main_pwr), .aux_pwr_o(aux_pwr),
    .pwr_ctl_o(pwr_ctl), .mdiv_sel_o(mdiv_sel), .offset_en_o(offset_en),
    .tx_mode_o(tx_mode), .dig_mode_o(dig_mode), .txlo_buf_en_o(txlo_en),
    .rclk_buf_en_o(rclk_en), .speedup_o(speedup), .upd_main_o(upd_main),
    .upd_ref_o(upd_ref), .upd_aux_o(upd_aux), .upd_ctl_o(upd_ctl)
  );

  typedef struct {int kind; logic [31:0] data; string req;} item_t;
  item_t exp_q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  function automatic logic [31:0] snap(int kind);
    case (kind)
      0: return {4'b0, frac_mod, frac_inc, main_ratio, comp_dac};
      1: return {18'b0, ref_ratio, main_tap, aux_tap};
      2: return {12'b0, aux_ratio, pump_ratio, lock_sel, main_pwr, aux_pwr};
      default: return {17'b0, pwr_ctl, mdiv_sel, offset_en, tx_mode, dig_mode, txlo_en, rclk_en};
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // monitor: every update pulse must match the head of the scoreboard
  always @(negedge clk) if (rst_ni && !done) begin
    automatic logic [3:0] p = {upd_ctl, upd_aux, upd_ref, upd_main};
    if (p != 0) begin
      automatic int k = upd_main ? 0 : upd_ref ? 1 : upd_aux ? 2 : 3;
      if ($countones(p) != 1) chk("R4 pulse count", 32'($countones(p)), 32'd1);
      else if (exp_q.size() == 0) chk("R3/R6 unexpected update", 32'(k), 32'hFFFF);
      else begin
        automatic item_t it = exp_q.pop_front();
        chk({it.req, " kind"}, 32'(k), 32'(it.kind));
        chk({it.req, " data"}, snap(k), it.data);
      end
    end
  end

  task automatic send_word(logic [23:0] w);
    for (int i = 0; i < 24; i++) begin
      @(negedge clk); ser_data = w[i]; ser_clk = 1'b1;
      @(negedge clk); ser_clk = 1'b0;
    end
  endtask

  task automatic strobe_load(int hold);
    @(negedge clk); ser_strobe = 1'b1;
    repeat (hold) @(negedge clk);
    ser_strobe = 1'b0;
    @(negedge clk);
  endtask

  task automatic sync_pulse();
    @(negedge clk); div_sync = 1'b1;
    @(negedge clk); div_sync = 1'b0;
  endtask

  function automatic item_t mk(int k, logic [31:0] d, string r);
    item_t it; it.kind = k; it.data = d; it.req = r; return it;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R8 reset defaults
    chk("R8 main", snap(0), {4'b0, 1'b0, 3'd0, 16'd1024, 8'd80});
    chk("R8 ref", snap(1), {18'b0, 10'd100, 2'd0, 2'd0});
    chk("R8 aux", snap(2), {12'b0, 14'd512, 6'd0});
    chk("R8 ctl", snap(3), 32'd0);
    chk("R8 speedup", 32'(speedup), 32'd0);

    // R4 aux word: ratio 0x2A5B, pump 2, lock 1, main_pwr 1, aux_pwr 0
    exp_q.push_back(mk(2, {12'b0, 14'h2A5B, 2'd2, 2'd1, 1'b1, 1'b0}, "R4 aux"));
    send_word({2'b10, 14'h2A5B, 2'd2, 2'd1, 1'b1, 1'b0, 2'b11});
    strobe_load(3);

    // R4 ctl word: pwr A5, mdiv 2, bits 10110
    exp_q.push_back(mk(3, {17'b0, 8'hA5, 2'd2, 5'b10110}, "R4 ctl"));
    send_word({3'b110, 8'hA5, 2'd2, 5'b10110, 6'b101010});
    strobe_load(3);

    // R3 reserved 111 word is ignored
    send_word({3'b111, 21'h1FFFFF});
    strobe_load(3);
    chk("R3 ctl unchanged", snap(3), {17'b0, 8'hA5, 2'd2, 5'b10110});
    chk("R3 aux unchanged", snap(2), {12'b0, 14'h2A5B, 2'd2, 2'd1, 1'b1, 1'b0});

    // R5 reference word stages DAC C3
    exp_q.push_back(mk(1, {18'b0, 10'h2CD, 2'd1, 2'd2}, "R4 ref"));
    send_word({2'b01, 10'h2CD, 2'd1, 2'd2, 8'hC3});
    strobe_load(3);
    chk("R5 dac not yet applied", 32'(comp_dac), 32'd80);

    // R1 serial clocks with strobe high are ignored; second rise reloads same word
    @(negedge clk); ser_strobe = 1'b1;
    exp_q.push_back(mk(1, {18'b0, 10'h2CD, 2'd1, 2'd2}, "R1 reload"));
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); ser_data = i[0]; ser_clk = 1'b1;
      @(negedge clk); ser_clk = 1'b0;
    end
    ser_strobe = 1'b0;
    @(negedge clk);
    exp_q.push_back(mk(1, {18'b0, 10'h2CD, 2'd1, 2'd2}, "R1 held word"));
    strobe_load(2);

    // R6 main word with no sync is dropped
    send_word({2'b00, 1'b1, 3'd5, 16'h8001, 2'b00});
    strobe_load(6);
    chk("R6 dropped main", snap(0), {4'b0, 1'b0, 3'd0, 16'd1024, 8'd80});
    chk("R7 no speedup w/o commit", 32'(speedup), 32'd0);

    // R5 second reference word: latest staged DAC wins
    exp_q.push_back(mk(1, {18'b0, 10'h155, 2'd3, 2'd0}, "R4 ref2"));
    send_word({2'b01, 10'h155, 2'd3, 2'd0, 8'h4D});
    strobe_load(2);

    // R6/R2/R5/R7 main word committed on sync
    send_word({2'b00, 1'b1, 3'd5, 16'h8001, 2'b00});
    @(negedge clk); ser_strobe = 1'b1;
    repeat (3) @(negedge clk);
    chk("R6 no commit before sync", snap(0), {4'b0, 1'b0, 3'd0, 16'd1024, 8'd80});
    chk("R7 speedup before sync", 32'(speedup), 32'd0);
    exp_q.push_back(mk(0, {4'b0, 1'b1, 3'd5, 16'h8001, 8'h4D}, "R2/R5/R6 main"));
    sync_pulse();
    chk("R7 speedup after commit", 32'(speedup), 32'd1);
    chk("R2 ratio lsb-first", 32'(main_ratio), 32'h8001);
    repeat (3) @(negedge clk);
    sync_pulse();  // R6: second sync in same strobe must not commit
    chk("R7 speedup held", 32'(speedup), 32'd1);
    ser_strobe = 1'b0;
    chk("R7 speedup until sampled low", 32'(speedup), 32'd1);
    @(negedge clk);
    chk("R7 speedup cleared", 32'(speedup), 32'd0);

    // R6 sync with nothing pending
    sync_pulse();
    chk("R6 idle sync", snap(0), {4'b0, 1'b1, 3'd5, 16'h8001, 8'h4D});

    // R6 another main word, sync one cycle after rise; staged DAC reused
    send_word({2'b00, 1'b0, 3'd2, 16'h1234, 2'b01});
    @(negedge clk); ser_strobe = 1'b1;
    exp_q.push_back(mk(0, {4'b0, 1'b0, 3'd2, 16'h1234, 8'h4D}, "R6 main2"));
    sync_pulse();
    @(negedge clk); ser_strobe = 1'b0;
    repeat (3) @(negedge clk);

    chk("R4/R6 scoreboard drained", 32'(exp_q.size()), 32'd0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule